// File: doc/BRIEF.md
# Timer Match Channel Bank

This block sits beside a free-running timer counter and watches its value through a bank of match channels. Each channel holds an active compare value. When the counter advances onto a value equal to a channel's compare value, the channel takes the actions it is configured for. It can latch an interrupt flag, ask the counter to restart from zero, ask the counter to halt, or change a persistent external output bit. The output bit can be kept, forced low, forced high or inverted.

A typical use is pulse-width modulation. One channel restarts the counter and so sets the period. The other channels drive output bits that are set at the start of a period and cleared at their own compare value. Every channel also has a shadow value. When reload is enabled, the shadow value is copied into the active compare value at the moment a match restarts the counter. A new pulse width or period therefore takes effect only on a period boundary.

The counter itself is not part of this block. It supplies the value and a strobe that marks each advance, and it consumes the restart and halt requests. All pins are plain control and status signals, and the block has no streaming interface, so there is no back-pressure.

Top module: `match_bank`

## Requirements
- R1: Channel n hits only in a cycle where `cnt_tick` is 1 and `cnt_val` equals its active value. If the counter stays on that value without a new strobe, the channel does not hit again.
- R2: `ctr_rst_req` is 1, combinationally in the same cycle, exactly when a channel hits while its restart bit `mctl[3n+1]` is 1.
- R3: `ctr_stop_req` is 1, combinationally in the same cycle, exactly when a channel hits while its halt bit `mctl[3n+2]` is 1.
- R4: A hit on channel n with `mctl[3n]` set makes `flags[n]` 1 from the next clock. Writing 1 to `flag_clr[n]` clears the flag from the next clock. `irq` is the OR of all flags.
- R5: If a hit and a clear of the same flag fall in the same cycle, the flag ends up 1.
- R6: On a hit, `ext_match[n]` follows the 2-bit code `oact[2n+1:2n]` from the next clock. The codes are 0 keep, 1 drive 0, 2 drive 1 and 3 invert. Without a hit or a load, the bit holds.
- R7: `ext_load` copies `ext_init` into every external match bit on the next clock, and it takes priority over any hit action.
- R8: When `ctr_rst_req` is 1, every channel with `rld_en[n]` set copies its shadow value (`shadow_val` slice n) into its active value on the next clock. Channels with `rld_en[n]` clear keep their value.
- R9: `wr_en[n]` loads `wr_val` into channel n's active value on the next clock. If a reload happens in the same cycle, the write wins. The active values can be read on `act_val`, with slice n belonging to channel n.
- R10: After reset, all flags, external match bits and active values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CW | Counter value, valid in the cycle of the strobe |
| cnt_tick | input | 1 | Counter advanced onto `cnt_val` this cycle |
| mctl | input | 3*NCH | Per channel: interrupt, restart and halt bits at 3n, 3n+1 and 3n+2 |
| oact | input | 2*NCH | Per-channel output action code |
| rld_en | input | NCH | Per-channel shadow reload enable |
| shadow_val | input | NCH*CW | Per-channel shadow values |
| wr_en | input | NCH | Per-channel active value write strobe |
| wr_val | input | CW | Data for the active value write |
| ext_init | input | NCH | Initial state of the external match bits |
| ext_load | input | 1 | Load `ext_init` into the external match bits |
| flag_clr | input | NCH | Write-1-to-clear for the flags |
| ctr_rst_req | output | 1 | Request to restart the counter |
| ctr_stop_req | output | 1 | Request to halt the counter |
| ext_match | output | NCH | External match bits |
| flags | output | NCH | Match interrupt flags |
| irq | output | 1 | OR of all flags |
| act_val | output | NCH*CW | Active compare values |

## Verification
The bench holds the counter on a matching value without a strobe. A design that compares on every clock would keep setting flags and keep inverting the output bits there. It sends a hit and a clear to the same flag in one cycle, where a design with the wrong priority would lose the interrupt. It also makes a restart match coincide with a host write to a channel that has reload enabled. A design with the wrong priority would keep the shadow value instead of the written one, or would reload channels whose reload enable is clear. Random traffic mixes all four output codes with initial-state loads, so a swapped code or a load that loses to a hit shows up as a wrong output bit.

// File: rtl/match_bank_pkg.sv
package match_bank_pkg;
  // bit positions inside one channel's 3-bit action group
  localparam int unsigned ACT_IRQ  = 0;
  localparam int unsigned ACT_RST  = 1;
  localparam int unsigned ACT_STOP = 2;
  localparam int unsigned ACT_W    = 3;
  localparam int unsigned OACT_W   = 2;

  typedef enum logic [1:0] {
    OA_KEEP = 2'd0,
    OA_LOW  = 2'd1,
    OA_HIGH = 2'd2,
    OA_INV  = 2'd3
  } oact_e;
endpackage

// File: rtl/match_chan.sv
module match_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] shadow,
  input  logic          rld_en,
  input  logic          rld_fire,
  output logic [CW-1:0] act,
  output logic          hit
);
  logic [CW-1:0] act_q;

  // compare only on a counter advance, so a held value fires once
  assign hit = cnt_tick && (cnt_val == act_q);
  assign act = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                act_q <= '0;
    else if (wr_en)            act_q <= wr_val;
    else if (rld_fire && rld_en) act_q <= shadow;
  end

  // R8
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_fire && rld_en && !wr_en) |=> (act == $past(shadow)));

  // R9
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (act == $past(wr_val)));

  // R1
  hit_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cnt_tick);
endmodule

// File: rtl/match_extout.sv
module match_extout
  import match_bank_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hit,
  input  logic [NCH*OACT_W-1:0] oact,
  input  logic [NCH-1:0]        ext_init,
  input  logic                  ext_load,
  output logic [NCH-1:0]        ext
);
  logic [NCH-1:0] ext_q;
  assign ext = ext_q;

  for (genvar n = 0; n < NCH; n++) begin : g_bit
    oact_e code;
    logic  nxt;
    assign code = oact_e'(oact[n*OACT_W +: OACT_W]);

    always_comb begin
      unique case (code)
        OA_LOW:  nxt = 1'b0;
        OA_HIGH: nxt = 1'b1;
        OA_INV:  nxt = ~ext_q[n];
        default: nxt = ext_q[n];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ext_q[n] <= 1'b0;
      else if (ext_load) ext_q[n] <= ext_init[n];
      else if (hit[n])   ext_q[n] <= nxt;
    end

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[n] && !ext_load) |=> $stable(ext[n]));

    // R6
    ext_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[n] && !ext_load && code == OA_INV) |=> (ext[n] != $past(ext[n])));

    // R7
    ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_load |=> (ext[n] == $past(ext_init[n])));
  end
endmodule

// File: rtl/match_flags.sv
module match_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] fl_q;
  assign flags = fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= (fl_q & ~clr) | set;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[n] |=> flags[n]);

    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[n] && !set[n]) |=> !flags[n]);
  end
endmodule

// File: rtl/match_bank.sv
module match_bank
  import match_bank_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         cnt_val,
  input  logic                  cnt_tick,
  input  logic [NCH*ACT_W-1:0]  mctl,
  input  logic [NCH*OACT_W-1:0] oact,
  input  logic [NCH-1:0]        rld_en,
  input  logic [NCH*CW-1:0]     shadow_val,
  input  logic [NCH-1:0]        wr_en,
  input  logic [CW-1:0]         wr_val,
  input  logic [NCH-1:0]        ext_init,
  input  logic                  ext_load,
  input  logic [NCH-1:0]        flag_clr,
  output logic                  ctr_rst_req,
  output logic                  ctr_stop_req,
  output logic [NCH-1:0]        ext_match,
  output logic [NCH-1:0]        flags,
  output logic                  irq,
  output logic [NCH*CW-1:0]     act_val
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] irq_set;
  logic [NCH-1:0] rst_hit;
  logic [NCH-1:0] stop_hit;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    match_chan #(.CW(CW)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_val  (cnt_val),
      .cnt_tick (cnt_tick),
      .wr_en    (wr_en[n]),
      .wr_val   (wr_val),
      .shadow   (shadow_val[n*CW +: CW]),
      .rld_en   (rld_en[n]),
      .rld_fire (ctr_rst_req),
      .act      (act_val[n*CW +: CW]),
      .hit      (hit[n])
    );
    assign irq_set[n]  = hit[n] & mctl[n*ACT_W + ACT_IRQ];
    assign rst_hit[n]  = hit[n] & mctl[n*ACT_W + ACT_RST];
    assign stop_hit[n] = hit[n] & mctl[n*ACT_W + ACT_STOP];
  end

  assign ctr_rst_req  = |rst_hit;
  assign ctr_stop_req = |stop_hit;

  match_extout #(.NCH(NCH)) ext_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .oact     (oact),
    .ext_init (ext_init),
    .ext_load (ext_load),
    .ext      (ext_match)
  );

  match_flags #(.NCH(NCH)) flg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign irq = |flags;

  // R2
  rst_req_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_rst_req |-> cnt_tick);

  // R3
  stop_req_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_stop_req |-> cnt_tick);

  // R4
  irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[0] |=> irq);
endmodule

// File: tb/match_bank_tb_top.sv
module match_bank_tb_top;
  localparam int unsigned NCH = 4;
  localparam int unsigned CW  = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [CW-1:0]       cnt_val = '0;
  logic                cnt_tick = 1'b0;
  logic [NCH*3-1:0]    mctl = '0;
  logic [NCH*2-1:0]    oact = '0;
  logic [NCH-1:0]      rld_en = '0;
  logic [NCH*CW-1:0]   shadow_val = '0;
  logic [NCH-1:0]      wr_en = '0;
  logic [CW-1:0]       wr_val = '0;
  logic [NCH-1:0]      ext_init = '0;
  logic                ext_load = 1'b0;
  logic [NCH-1:0]      flag_clr = '0;
  logic                ctr_rst_req, ctr_stop_req, irq;
  logic [NCH-1:0]      ext_match, flags;
  logic [NCH*CW-1:0]   act_val;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [CW-1:0]  m_mr [NCH];
  logic [NCH-1:0] m_ext;
  logic [NCH-1:0] m_flag;

  always #4 clk = ~clk;

  match_bank #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .mctl(mctl), .oact(oact), .rld_en(rld_en), .shadow_val(shadow_val),
    .wr_en(wr_en), .wr_val(wr_val), .ext_init(ext_init), .ext_load(ext_load),
    .flag_clr(flag_clr), .ctr_rst_req(ctr_rst_req), .ctr_stop_req(ctr_stop_req),
    .ext_match(ext_match), .flags(flags), .irq(irq), .act_val(act_val)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic apply_code(input logic cur, input logic [1:0] code);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [NCH-1:0] exp_hits();
    logic [NCH-1:0] h;
    for (int n = 0; n < NCH; n++) h[n] = cnt_tick && (cnt_val == m_mr[n]);
    return h;
  endfunction

  function automatic logic [NCH-1:0] pick_bits(input int ofs);
    logic [NCH-1:0] b;
    for (int n = 0; n < NCH; n++) b[n] = mctl[3*n + ofs];
    return b;
  endfunction

  // inputs already driven (after a falling edge); check, advance model, check
  task automatic step();
    logic [NCH-1:0] h;
    logic rq;
    #1;
    h  = exp_hits();
    rq = |(h & pick_bits(1));
    chk("R2 restart request", ctr_rst_req, rq);
    chk("R3 halt request", ctr_stop_req, |(h & pick_bits(2)));
    m_flag = (m_flag & ~flag_clr) | (h & pick_bits(0));
    for (int n = 0; n < NCH; n++) begin
      if (ext_load)  m_ext[n] = ext_init[n];
      else if (h[n]) m_ext[n] = apply_code(m_ext[n], oact[2*n +: 2]);
      if (wr_en[n])            m_mr[n] = wr_val;
      else if (rq && rld_en[n]) m_mr[n] = shadow_val[n*CW +: CW];
    end
    @(negedge clk);
    chk("R4 R5 flags", flags, m_flag);
    chk("R4 irq", irq, |m_flag);
    chk("R6 R7 ext match", ext_match, m_ext);
    for (int n = 0; n < NCH; n++)
      chk("R8 R9 active value", act_val[n*CW +: CW], m_mr[n]);
  endtask

  task automatic idle();
    cnt_tick = 0; wr_en = '0; ext_load = 0; flag_clr = '0;
  endtask

  initial begin : watchdog
    #1600000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7321));
    for (int n = 0; n < NCH; n++) m_mr[n] = '0;
    m_ext = '0; m_flag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flags", flags, 0);
    chk("R10 ext", ext_match, 0);
    chk("R10 active", act_val, 0);
    chk("R10 irq", irq, 0);

    // R1: equal value without strobe does not hit
    idle(); wr_en = 4'b0001; wr_val = 16'd5; step();
    idle(); mctl = 12'b001; oact = 8'b11; cnt_val = 16'd5; step();
    chk("R1 no strobe no flag", flags[0], 1'b0);
    cnt_tick = 1; step();
    chk("R1 strobe sets flag", flags[0], 1'b1);
    chk("R6 invert on hit", ext_match[0], 1'b1);
    idle(); flag_clr = 4'b0001; step();
    idle(); step(); step();
    chk("R1 held value does not refire", flags[0], 1'b0);
    chk("R1 held value no second invert", ext_match[0], 1'b1);

    // R5: hit and clear in same cycle
    cnt_tick = 1; flag_clr = 4'b0001; step();
    chk("R5 set beats clear", flags[0], 1'b1);

    // R7 priority over hit
    idle(); ext_init = 4'b0000; ext_load = 1; cnt_tick = 1; oact = 8'b10; step();
    chk("R7 load beats hit", ext_match[0], 1'b0);

    // R8/R9: ch0 restarts; ch2 reloads, ch1 reload+write, ch3 no reload
    idle(); mctl = 12'b000_000_000_010; rld_en = 4'b0110;
    shadow_val = {16'd33, 16'd22, 16'd11, 16'd44};
    wr_en = 4'b0010; wr_val = 16'd77; cnt_tick = 1; cnt_val = 16'd5; step();
    chk("R8 reload from shadow", act_val[2*CW +: CW], 16'd22);
    chk("R9 write beats reload", act_val[1*CW +: CW], 16'd77);
    chk("R8 no reload without enable", act_val[3*CW +: CW], 16'd0);
    chk("R8 channel zero kept", act_val[0 +: CW], 16'd5);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0) begin
        mctl = $urandom(); oact = $urandom(); rld_en = $urandom();
        for (int n = 0; n < NCH; n++) shadow_val[n*CW +: CW] = CW'($urandom_range(0, 7));
      end
      cnt_tick = ($urandom_range(0, 2) != 0);
      cnt_val  = CW'($urandom_range(0, 7));
      flag_clr = ($urandom_range(0, 3) == 0) ? NCH'($urandom()) : '0;
      wr_en    = ($urandom_range(0, 7) == 0) ? NCH'($urandom()) : '0;
      wr_val   = CW'($urandom_range(0, 7));
      ext_load = ($urandom_range(0, 15) == 0);
      ext_init = NCH'($urandom());
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule